// File: doc/BRIEF.md
# DDR SDRAM Refresh and Low-Power Mode Manager

This block sits beside the bank tracker of a DDR SDRAM controller. It keeps the attached memory refreshed and moves the device between normal operation, self-refresh and power-down. An interval down-counter raises a refresh request. Once the request is raised, the block blocks normal traffic through `busy`. If every bank is idle, it issues an auto-refresh command. If a row is still open, it first issues a precharge-all, waits the row-precharge time and then refreshes. After each refresh it holds `busy` for the refresh cycle time.

A host asks for a low-power mode with a one-cycle `sleep_req`. `sleep_deep` selects the mode: 1 requests self-refresh and 0 requests power-down. The request is latched until a one-cycle `wake_req` clears it.

- **Self-refresh** is entered only with all banks idle. Entry is a self-refresh command with CKE driven low in the same cycle. On wake, CKE rises and the block waits a recovery time. It then issues a mandatory auto-refresh and holds `read_hold` high until the DLL has had time to relock.
- **Power-down** is entered with banks idle or a row active. If a refresh falls due during power-down, the block leaves power-down on its own, refreshes and returns to power-down.

All pins are plain control and status levels or one-cycle strobes. The block carries no data stream, so it has no valid/ready handshake and no back-pressure. All command outputs decode the registered state and do not depend combinationally on the inputs. Inputs are sampled at the rising clock edge.

Top module: `dram_refresh_pm`

## Requirements
- R1: While reset is held and in the first cycle after it, `cke` is 1 and `cmd_pre_all`, `cmd_refresh`, `cmd_self_refresh`, `busy`, `refresh_pending` and `read_hold` are all 0.
- R2: `refresh_pending` rises exactly REFI_CYC cycles after the cycle that carries an auto-refresh command. It stays high through any precharge and wait until the next auto-refresh command, and it is low in the cycle after that command.
- R3: When `refresh_pending` is high in normal mode with `banks_idle` = 1, `cmd_refresh` is issued in the next cycle and no precharge-all is issued.
- R4: When `refresh_pending` is high in normal mode with `banks_idle` = 0, `cmd_pre_all` is issued in the next cycle and `cmd_refresh` follows exactly TRP_CYC cycles after the precharge-all.
- R5: `busy` is high whenever `refresh_pending` is high or the block is outside normal mode. After an auto-refresh command issued from normal mode, the first cycle with `busy` low is exactly TRFC_CYC cycles after the command.
- R6: A latched self-refresh request (`sleep_deep` = 1) is acted on only while `banks_idle` = 1. The entry cycle shows `cmd_self_refresh` = 1 with `cke` = 0, one cycle after the request or after `banks_idle` rises. While self-refresh lasts, `cke` stays 0, no refresh request rises and no auto-refresh is issued, however long it lasts.
- R7: A latched power-down request (`sleep_deep` = 0) takes `cke` low without any command in the cycle after `banks_idle` or `row_active` is 1. While both are 0, entry is deferred.
- R8: A wake in self-refresh raises `cke` in the next cycle. An auto-refresh is issued exactly XSNR_CYC cycles after `cke` rises. `read_hold` is high for exactly DLL_LOCK_CYC cycles starting with the `cke` rise. The device is not put back to sleep afterwards.
- R9: A wake in power-down raises `cke` in the next cycle. `busy` stays high for exactly PDX_CYC cycles from that rise and `read_hold` stays 0.
- R10: A refresh falling due in power-down raises `cke` in the next cycle, issues an auto-refresh PDX_CYC+1 cycles after the rise with banks idle, and drops `cke` again TRFC_CYC+1 cycles after that refresh, with no new request.
- R11: At most one command output is high in any cycle. No precharge-all or auto-refresh is issued while `cke` is 0. After `cke` rises it stays high in the next cycle.
- R12: A wake in normal mode has no effect on `cke` or `busy`. It also discards a sleep request that has not yet been acted on, so that request is not acted on later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_idle | input | 1 | From the bank tracker: every bank is precharged |
| row_active | input | 1 | From the bank tracker: at least one row is open and no bank is in transition |
| sleep_req | input | 1 | One-cycle request to enter a low-power mode |
| sleep_deep | input | 1 | Mode for `sleep_req`: 1 = self-refresh, 0 = power-down |
| wake_req | input | 1 | One-cycle request to leave a low-power mode or drop an unserved request |
| cmd_pre_all | output | 1 | Issue precharge-all this cycle |
| cmd_refresh | output | 1 | Issue auto-refresh this cycle |
| cmd_self_refresh | output | 1 | Issue self-refresh entry this cycle (with `cke` low) |
| cke | output | 1 | Clock-enable level for the device |
| busy | output | 1 | Normal traffic must not be issued |
| refresh_pending | output | 1 | A refresh is due and not yet served |
| read_hold | output | 1 | Read commands must not be issued (DLL relock after self-refresh) |

## Verification
The bench targets the refresh deadline and the two refresh paths: it checks that the precharge-all precedes the refresh by exactly TRP_CYC cycles and that the refresh request survives the precharge wait. A design that cleared the request early, or refreshed with a row open, would show up as a missing or early command. The entry preconditions are tested by holding the bank tracker in states that forbid entry, and by cancelling a request with a wake before it is served. A design that entered self-refresh with rows open, or acted on a stale request, would drop `cke` when it must stay high. The post-exit rules are measured at their exact boundary cycles: the mandatory refresh after self-refresh, the last cycle of `read_hold`, the end of `busy` after power-down, and the automatic wake-refresh-resleep loop inside power-down. An off-by-one counter or a missing return to power-down fails there, as does a timer that keeps running during self-refresh.

// File: rtl/drpm_pkg.sv
`timescale 1ns/1ps
package drpm_pkg;

  typedef enum logic [3:0] {
    PM_RUN,       // normal traffic allowed
    PM_PRE,       // precharge-all issued
    PM_TRP,       // waiting row-precharge time
    PM_REF,       // auto-refresh issued
    PM_TRFC,      // waiting refresh cycle time
    PM_SR_ENTER,  // self-refresh command with CKE low
    PM_SR,        // resting in self-refresh
    PM_SR_EXIT,   // CKE high, recovering before mandatory refresh
    PM_PD,        // resting in power-down
    PM_PD_EXIT    // CKE high, power-down exit recovery
  } pm_state_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/drpm_interval_timer.sv
`timescale 1ns/1ps
module drpm_interval_timer #(
  parameter int REFI_CYC = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  output logic due
);
  localparam int CW = $clog2(REFI_CYC);
  localparam logic [CW-1:0] RELOAD_V = CW'(REFI_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= RELOAD_V;
      due <= 1'b0;
    end else if (reload) begin
      cnt <= RELOAD_V;
      due <= 1'b0;
    end else begin
      if (cnt != '0) cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) due <= 1'b1;
    end
  end

  // R2: a raised request is held until a refresh serves it
  p_pending_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    due && !reload |=> due);
  // R2: serving the request clears it in the following cycle
  p_pending_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !due);

endmodule

// File: rtl/drpm_wait_counter.sv
`timescale 1ns/1ps
module drpm_wait_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= value;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign done = (cnt == '0);

  p_wait_counts_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !done |=> $past(cnt) - W'(1) == cnt);

endmodule

// File: rtl/drpm_dll_guard.sv
`timescale 1ns/1ps
module drpm_dll_guard #(
  parameter int DLL_LOCK_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic read_hold
);
  localparam int CW = $clog2(DLL_LOCK_CYC + 1);
  localparam logic [CW-1:0] LOCK_V = CW'(DLL_LOCK_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (start)     cnt <= LOCK_V;
    else if (cnt != '0) cnt <= cnt - CW'(1);
  end

  assign read_hold = (cnt != '0);

  // R8: reads are held off from the first cycle after a self-refresh exit
  p_hold_after_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> read_hold);

endmodule

// File: rtl/drpm_mode_fsm.sv
`timescale 1ns/1ps
module drpm_mode_fsm
  import drpm_pkg::*;
#(
  parameter int TRP_CYC  = 4,
  parameter int TRFC_CYC = 15,
  parameter int XSNR_CYC = 16,
  parameter int PDX_CYC  = 1,
  parameter int WAIT_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              banks_idle,
  input  logic              row_active,
  input  logic              sleep_req,
  input  logic              sleep_deep,
  input  logic              wake_req,
  input  logic              refresh_due,
  input  logic              wait_done,
  output logic              wait_load,
  output logic [WAIT_W-1:0] wait_value,
  output logic              cmd_pre_all,
  output logic              cmd_refresh,
  output logic              cmd_self_refresh,
  output logic              cke,
  output logic              busy,
  output logic              sr_exit_start,
  output logic              in_self_refresh
);
  localparam logic [WAIT_W-1:0] V_TRP  = WAIT_W'(TRP_CYC - 2);
  localparam logic [WAIT_W-1:0] V_TRFC = WAIT_W'(TRFC_CYC - 2);
  localparam logic [WAIT_W-1:0] V_XSNR = WAIT_W'(XSNR_CYC - 1);
  localparam logic [WAIT_W-1:0] V_PDX  = WAIT_W'(PDX_CYC - 1);

  pm_state_t st, nxt;
  logic want_q, deep_q;
  logic want_eff, deep_eff;

  // latched low-power intent; a wake always wins
  assign want_eff = !wake_req && (sleep_req || want_q);
  assign deep_eff = sleep_req ? sleep_deep : deep_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      want_q <= 1'b0;
      deep_q <= 1'b0;
    end else begin
      if (wake_req)       want_q <= 1'b0;
      else if (sleep_req) want_q <= 1'b1;
      if (sleep_req)      deep_q <= sleep_deep;
    end
  end

  always_comb begin
    nxt        = st;
    wait_load  = 1'b0;
    wait_value = '0;
    case (st)
      PM_RUN: begin
        if (refresh_due) begin
          nxt = banks_idle ? PM_REF : PM_PRE;
        end else if (want_eff && deep_eff && banks_idle) begin
          nxt = PM_SR_ENTER;
        end else if (want_eff && !deep_eff && (banks_idle || row_active)) begin
          nxt = PM_PD;
        end
      end
      PM_PRE: begin
        nxt        = PM_TRP;
        wait_load  = 1'b1;
        wait_value = V_TRP;
      end
      PM_TRP:      if (wait_done) nxt = PM_REF;
      PM_REF: begin
        nxt        = PM_TRFC;
        wait_load  = 1'b1;
        wait_value = V_TRFC;
      end
      PM_TRFC:     if (wait_done) nxt = PM_RUN;
      PM_SR_ENTER: nxt = PM_SR;
      PM_SR: begin
        if (wake_req) begin
          nxt        = PM_SR_EXIT;
          wait_load  = 1'b1;
          wait_value = V_XSNR;
        end
      end
      PM_SR_EXIT:  if (wait_done) nxt = PM_REF;
      PM_PD: begin
        if (wake_req || refresh_due) begin
          nxt        = PM_PD_EXIT;
          wait_load  = 1'b1;
          wait_value = V_PDX;
        end
      end
      PM_PD_EXIT:  if (wait_done) nxt = PM_RUN;
      default:     nxt = PM_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= PM_RUN;
    else        st <= nxt;
  end

  assign cmd_pre_all      = (st == PM_PRE);
  assign cmd_refresh      = (st == PM_REF);
  assign cmd_self_refresh = (st == PM_SR_ENTER);
  assign cke              = !(st == PM_SR_ENTER || st == PM_SR || st == PM_PD);
  assign busy             = (st != PM_RUN) || refresh_due;
  assign sr_exit_start    = (st == PM_SR) && wake_req;
  assign in_self_refresh  = (st == PM_SR_ENTER) || (st == PM_SR) || (st == PM_SR_EXIT);

  p_one_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_pre_all, cmd_refresh, cmd_self_refresh}));
  p_no_cmd_cke_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> !(cmd_pre_all || cmd_refresh));
  p_cke_rise_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |=> cke);
  p_sr_needs_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_self_refresh) |-> $past(banks_idle));
  p_pd_precond_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) && !cmd_self_refresh |-> $past(banks_idle || row_active));
  p_busy_asleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> busy);

endmodule

// File: rtl/dram_refresh_pm.sv
`timescale 1ns/1ps
module dram_refresh_pm
  import drpm_pkg::*;
#(
  parameter int REFI_CYC     = 1560,
  parameter int TRP_CYC      = 4,
  parameter int TRFC_CYC     = 15,
  parameter int XSNR_CYC     = 16,
  parameter int DLL_LOCK_CYC = 200,
  parameter int PDX_CYC      = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic banks_idle,
  input  logic row_active,
  input  logic sleep_req,
  input  logic sleep_deep,
  input  logic wake_req,
  output logic cmd_pre_all,
  output logic cmd_refresh,
  output logic cmd_self_refresh,
  output logic cke,
  output logic busy,
  output logic refresh_pending,
  output logic read_hold
);
  localparam int WAIT_MAX = max_of(max_of(TRP_CYC, TRFC_CYC), max_of(XSNR_CYC, PDX_CYC));
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

  logic              refresh_due;
  logic              timer_reload;
  logic              wait_load;
  logic [WAIT_W-1:0] wait_value;
  logic              wait_done;
  logic              sr_exit_start;
  logic              in_self_refresh;

  // the device refreshes itself in self-refresh, so the timer is held
  assign timer_reload    = cmd_refresh || in_self_refresh;
  assign refresh_pending = refresh_due;

  drpm_interval_timer #(.REFI_CYC(REFI_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (timer_reload),
    .due    (refresh_due)
  );

  drpm_wait_counter #(.W(WAIT_W)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wait_load),
    .value (wait_value),
    .done  (wait_done)
  );

  drpm_dll_guard #(.DLL_LOCK_CYC(DLL_LOCK_CYC)) u_dll (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (sr_exit_start),
    .read_hold (read_hold)
  );

  drpm_mode_fsm #(
    .TRP_CYC  (TRP_CYC),
    .TRFC_CYC (TRFC_CYC),
    .XSNR_CYC (XSNR_CYC),
    .PDX_CYC  (PDX_CYC),
    .WAIT_W   (WAIT_W)
  ) u_fsm (
    .clk              (clk),
    .rst_n            (rst_n),
    .banks_idle       (banks_idle),
    .row_active       (row_active),
    .sleep_req        (sleep_req),
    .sleep_deep       (sleep_deep),
    .wake_req         (wake_req),
    .refresh_due      (refresh_due),
    .wait_done        (wait_done),
    .wait_load        (wait_load),
    .wait_value       (wait_value),
    .cmd_pre_all      (cmd_pre_all),
    .cmd_refresh      (cmd_refresh),
    .cmd_self_refresh (cmd_self_refresh),
    .cke              (cke),
    .busy             (busy),
    .sr_exit_start    (sr_exit_start),
    .in_self_refresh  (in_self_refresh)
  );

  // R3: with a request pending and banks idle, no precharge-all is issued
  p_idle_no_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre_all |-> $past(!banks_idle));
  // R8: the mandatory refresh only ever follows with CKE already high
  p_refresh_cke_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_refresh |-> $past(cke));

endmodule

// File: tb/dram_refresh_pm_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_pm_tb_top;
  localparam int REFI = 300;
  localparam int TRP  = 3;
  localparam int TRFC = 8;
  localparam int XSNR = 10;
  localparam int DLL  = 200;
  localparam int PDX  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic banks_idle = 1'b1, row_active = 1'b0;
  logic sleep_req = 1'b0, sleep_deep = 1'b0, wake_req = 1'b0;
  logic cmd_pre_all, cmd_refresh, cmd_self_refresh, cke, busy, refresh_pending, read_hold;

  int n_vec = 0;
  int n_bad = 0;
  int r11_viol = 0;

  always #2.5 clk = ~clk;

  dram_refresh_pm #(
    .REFI_CYC(REFI), .TRP_CYC(TRP), .TRFC_CYC(TRFC),
    .XSNR_CYC(XSNR), .DLL_LOCK_CYC(DLL), .PDX_CYC(PDX)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .row_active(row_active),
    .sleep_req(sleep_req), .sleep_deep(sleep_deep), .wake_req(wake_req),
    .cmd_pre_all(cmd_pre_all), .cmd_refresh(cmd_refresh),
    .cmd_self_refresh(cmd_self_refresh), .cke(cke), .busy(busy),
    .refresh_pending(refresh_pending), .read_hold(read_hold)
  );

  // R11 monitor: command exclusivity and no refresh/precharge with CKE low
  always @(negedge clk) begin
    if (rst_n) begin
      if ((int'(cmd_pre_all) + int'(cmd_refresh) + int'(cmd_self_refresh)) > 1 ||
          (!cke && (cmd_pre_all || cmd_refresh)))
        r11_viol++;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic wait_pending(input string tag);
    int found = 0;
    for (int i = 0; i < REFI + 50 && found == 0; i++) begin
      tick();
      if (refresh_pending) found = 1;
    end
    chk(tag, "refresh request seen", found, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    chk("R1", "cke in reset", int'(cke), 1);
    rst_n = 1'b1;
    tick();
    chk("R1", "cke", int'(cke), 1);
    chk("R1", "commands", int'(cmd_pre_all | cmd_refresh | cmd_self_refresh), 0);
    chk("R1", "busy/pending/read_hold", int'(busy | refresh_pending | read_hold), 0);
  endtask

  task automatic t_refresh_idle();
    banks_idle = 1'b1; row_active = 1'b0;
    wait_pending("R2");
    chk("R5", "busy with request pending", int'(busy), 1);
    tick();
    chk("R3", "refresh after request", int'(cmd_refresh), 1);
    chk("R3", "no precharge", int'(cmd_pre_all), 0);
    for (int j = 1; j <= REFI - 1; j++) begin
      tick();
      if (j == 1)        chk("R2", "request cleared", int'(refresh_pending), 0);
      if (j == TRFC - 1) chk("R5", "busy last refresh cycle", int'(busy), 1);
      if (j == TRFC)     chk("R5", "busy released", int'(busy), 0);
      if (j == REFI - 1) chk("R2", "no early request", int'(refresh_pending), 0);
    end
  endtask

  task automatic t_refresh_open();
    banks_idle = 1'b0; row_active = 1'b1;
    tick();
    chk("R2", "request at interval", int'(refresh_pending), 1);
    tick();
    chk("R4", "precharge-all first", int'(cmd_pre_all), 1);
    chk("R2", "request held over precharge", int'(refresh_pending), 1);
    for (int j = 2; j <= TRP; j++) begin
      tick();
      chk("R4", "no refresh during tRP", int'(cmd_refresh), 0);
    end
    tick();
    chk("R4", "refresh tRP after precharge", int'(cmd_refresh), 1);
    banks_idle = 1'b1; row_active = 1'b0;
    repeat (TRFC) tick();
    chk("R5", "busy released after open-row refresh", int'(busy), 0);
  endtask

  task automatic t_self_refresh();
    int bad_hold = 0;
    banks_idle = 1'b0; row_active = 1'b1;
    sleep_req = 1'b1; sleep_deep = 1'b1;
    tick();
    sleep_req = 1'b0;
    for (int j = 0; j < 4; j++) begin
      tick();
      if (!cke || cmd_self_refresh) bad_hold++;
    end
    chk("R6", "no entry with row open", bad_hold, 0);
    banks_idle = 1'b1; row_active = 1'b0;
    tick();
    chk("R6", "self-refresh command", int'(cmd_self_refresh), 1);
    chk("R6", "cke low on entry", int'(cke), 0);
    bad_hold = 0;
    for (int j = 0; j < REFI + 20; j++) begin
      tick();
      if (cke || refresh_pending || cmd_refresh || cmd_self_refresh) bad_hold++;
    end
    chk("R6", "asleep with timer held", bad_hold, 0);
    wake_req = 1'b1;
    tick();
    wake_req = 1'b0;
    chk("R8", "cke up after wake", int'(cke), 1);
    chk("R8", "read hold at exit", int'(read_hold), 1);
    for (int j = 2; j <= DLL + 1; j++) begin
      tick();
      if (j == XSNR)     chk("R8", "no early refresh", int'(cmd_refresh), 0);
      if (j == XSNR + 1) chk("R8", "mandatory refresh", int'(cmd_refresh), 1);
      if (j == DLL)      chk("R8", "read hold last cycle", int'(read_hold), 1);
      if (j == DLL + 1)  chk("R8", "read hold released", int'(read_hold), 0);
    end
    chk("R8", "stays awake", int'(cke), 1);
    chk("R8", "not busy", int'(busy), 0);
  endtask

  task automatic t_power_down();
    banks_idle = 1'b0; row_active = 1'b0;
    sleep_req = 1'b1; sleep_deep = 1'b0;
    tick();
    sleep_req = 1'b0;
    repeat (3) tick();
    chk("R7", "deferred while banks in transition", int'(cke), 1);
    row_active = 1'b1;
    tick();
    chk("R7", "cke low with row active", int'(cke), 0);
    chk("R7", "no command on entry", int'(cmd_pre_all | cmd_refresh | cmd_self_refresh), 0);
    repeat (4) tick();
    chk("R7", "held in power-down", int'(cke), 0);
    wake_req = 1'b1;
    tick();
    wake_req = 1'b0;
    chk("R9", "cke up after wake", int'(cke), 1);
    for (int j = 2; j <= PDX + 1; j++) begin
      tick();
      if (j == PDX)     chk("R9", "busy in exit recovery", int'(busy), 1);
      if (j == PDX + 1) chk("R9", "busy released", int'(busy), 0);
    end
    chk("R9", "no read hold", int'(read_hold), 0);
  endtask

  task automatic t_pd_refresh();
    banks_idle = 1'b1; row_active = 1'b0;
    sleep_req = 1'b1; sleep_deep = 1'b0;
    tick();
    sleep_req = 1'b0;
    chk("R7", "power-down with banks idle", int'(cke), 0);
    wait_pending("R10");
    chk("R10", "asleep when refresh due", int'(cke), 0);
    tick();
    chk("R10", "cke up for refresh", int'(cke), 1);
    repeat (PDX) tick();
    chk("R10", "no refresh before recovery", int'(cmd_refresh), 0);
    tick();
    chk("R10", "refresh after power-down exit", int'(cmd_refresh), 1);
    repeat (TRFC) tick();
    chk("R10", "awake at end of refresh", int'(cke), 1);
    tick();
    chk("R10", "back in power-down", int'(cke), 0);
    repeat (2) tick();
    wake_req = 1'b1;
    tick();
    wake_req = 1'b0;
    repeat (PDX) tick();
    chk("R9", "awake after final wake", int'(cke & ~busy), 1);
  endtask

  task automatic t_wake_ignored();
    int bad = 0;
    wake_req = 1'b1;
    tick();
    wake_req = 1'b0;
    for (int j = 0; j < 3; j++) begin
      tick();
      if (!cke || busy) bad++;
    end
    chk("R12", "wake in normal mode", bad, 0);
    banks_idle = 1'b0; row_active = 1'b0;
    sleep_req = 1'b1; sleep_deep = 1'b1;
    tick();
    sleep_req = 1'b0;
    wake_req = 1'b1;
    tick();
    wake_req = 1'b0;
    banks_idle = 1'b1;
    bad = 0;
    for (int j = 0; j < 6; j++) begin
      tick();
      if (!cke || cmd_self_refresh) bad++;
    end
    chk("R12", "cancelled request not served", bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_refresh_idle();
    t_refresh_open();
    t_self_refresh();
    t_power_down();
    t_pd_refresh();
    t_wake_ignored();
    chk("R11", "command/cke violations", r11_viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule